// File: doc/BRIEF.md
# Receive Descriptor Chaining Engine

This block takes the bytes of received frames and stores them in host memory buffers. The buffers are described by a ring of two-word receive descriptors. Word 0 of a descriptor is the 32-bit byte address of its buffer. Word 1 is the status/control word, and the host and the engine pass it between them through an ownership bit.

When a frame begins, the engine reads the status word of the current descriptor and waits until it owns that descriptor. It then fetches the buffer address and writes the frame one byte at a time. A frame longer than one buffer continues into the next descriptors: the engine reads ahead to check ownership of the next descriptor before it releases the current one. Each descriptor is released by a single write-back that carries:

- the start-of-packet and end-of-packet markers,
- the error flags,
- a cleared ownership bit.

A missing next descriptor or a receive FIFO overflow ends the frame early. The engine then releases the current descriptor with the matching error, discards the rest of the frame, and resumes at the next ring entry.

The ring length, the ring base address and the fixed buffer size are parameters. All memory traffic uses one simple request/acknowledge port.

Top module: `rx_desc_chain`

## Requirements
- R1: After reset, `in_ready` and `mem_req` are low and the first frame is placed using descriptor 0 at `RING_BASE`. Descriptor i occupies the byte addresses `RING_BASE + 8*i` (buffer address word) and `RING_BASE + 8*i + 4` (status word).
- R2: The engine uses a descriptor only when bit 31 of its status word is 1. While the current descriptor reads back with bit 31 = 0, the engine keeps re-reading it, accepts no frame byte and writes nothing. Every memory request stays asserted with a stable address and direction until `mem_ack`.
- R3: Byte n of the part of a frame held in a buffer is written to byte address `buffer address + n`. The write is a single request whose `mem_wstrb` is the one-hot lane `1 << addr[1:0]`, with the byte copied into all four lanes of `mem_wdata`.
- R4: A frame fills buffers of `BUF_BYTES` bytes in ring order. Status bit 25 (start of packet) is set only in its first descriptor, and bit 24 (end of packet) only in its last. A frame of at most `BUF_BYTES` bytes gets both bits in one descriptor.
- R5: Releasing a descriptor is one full-word write (`mem_wstrb` = 4'hF) of its status word. Bit 31 is cleared, bits 31:24 carry the new flags, and bits 23:0 are written back unchanged. Descriptors beyond the last one used are neither written nor modified.
- R6: After the last ring entry the descriptor index wraps to 0.
- R7: Status bit 30 is the OR of bits 29, 28, 27 and 26 and of a `bus_perr` pulse seen since the previous release in the same frame.
- R8: Bit 29 (framing) is set only in the end-of-packet descriptor, and only when the last byte carried both `in_fcs_err` and `in_dribble`. Dribble alone leaves it clear.
- R9: Bit 27 (CRC) is set only in the end-of-packet descriptor, when the last byte carried `in_fcs_err` or any byte of the frame carried `in_phy_err`.
- R10: When a frame needs another buffer and the next descriptor's bit 31 is 0, the current descriptor is released with bit 26 (buffer error) and bit 30 set and bit 24 clear. The rest of the frame is discarded, and the next frame starts at that unowned descriptor, which is left unmodified.
- R11: When `in_overflow` accompanies a byte offered while the engine is filling a buffer, that byte is not stored. The current descriptor is released with bit 28 (overflow) and bit 30 set and with bits 24, 27 and 29 clear. The rest of the frame is discarded, and the next frame starts at the following descriptor.
- R12: When `in_overflow` accompanies the byte that caused the read-ahead, and the next descriptor turns out not to be owned, bits 26 and 28 are both set.
- R13: With `lookahead_en` high, bit 25 of each released descriptor is the value the host wrote, not the value computed by the engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lookahead_en | input | 1 | Keep host-written start-of-packet bit |
| bus_perr | input | 1 | Bus parity error pulse, folded into the summary error |
| in_valid | input | 1 | Frame byte offered |
| in_ready | output | 1 | Frame byte accepted this cycle when both are high |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Byte is the last of its frame |
| in_fcs_err | input | 1 | FCS check failed (with the last byte) |
| in_dribble | input | 1 | Frame length not a whole number of bytes (with the last byte) |
| in_phy_err | input | 1 | PHY receive error on this byte |
| in_overflow | input | 1 | Receive FIFO overflowed (with the offered byte) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_wstrb | output | 4 | Byte lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Request completed |

## Verification
The bench sweeps every frame length from 1 to 20 bytes over an 8-byte buffer and a 4-entry ring. This covers the exact-fit lengths 8 and 16, the lengths one byte past them, and several ring wraps. A design that peeked the next descriptor too early would fail on the exact fits by consuming or clearing an extra descriptor; a design with an off-by-one index would break on the wraps. All eight combinations of FCS, dribble and PHY errors are applied to a two-buffer frame. A design that leaked framing or CRC bits into the first descriptor, or set framing on dribble alone, is caught there. Four further cases are checked:

- an unowned next descriptor,
- overflow in mid-buffer,
- overflow at a buffer boundary with the next descriptor owned, and with it unowned,
- a frame that must wait for ownership.

These show whether the engine touches descriptors it does not own, mixes up which error goes with which, or writes bytes that follow an overflow.

// File: rtl/rxc_pkg.sv
// Shared types for the receive descriptor chaining engine.
// Assumes a 32-bit status word whose top byte holds the flags in the
// order of rxc_flags_t (bit 31 down to bit 24).
package rxc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_STAT,
        ST_RD_ADDR,
        ST_DATA,
        ST_WR_BYTE,
        ST_PEEK,
        ST_WB,
        ST_DRAIN
    } rxc_state_t;

    typedef enum logic [1:0] {
        WB_END,
        WB_CHAIN,
        WB_ABORT
    } rxc_wb_kind_t;

    typedef struct packed {
        logic own;
        logic err;
        logic fram;
        logic oflo;
        logic crc;
        logic buff;
        logic stp;
        logic enp;
    } rxc_flags_t;

    localparam int OWN_BIT = 31;
    localparam int STP_BIT = 25;
    localparam int STAT_KEEP_W = 24;

endpackage

// File: rtl/rxc_ring_ptr.sv
// Ring pointer: holds the current descriptor index and derives the byte
// addresses of the current and next descriptors. Assumes 8-byte
// descriptors laid out contiguously from RING_BASE; advance is a
// single-cycle pulse issued once per released descriptor.
module rxc_ring_ptr #(
    parameter int          RING_LEN  = 4,
    parameter logic [31:0] RING_BASE = 32'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        advance,
    output logic [31:0] cur_base,
    output logic [31:0] nxt_base
);

    localparam int IDX_W = (RING_LEN > 1) ? $clog2(RING_LEN) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(RING_LEN - 1);

    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] idx_nxt;

    // Successor index with wrap after the last ring entry.
    always_comb begin
        idx_nxt = (idx == IDX_LAST) ? '0 : idx + IDX_W'(1);
    end

    // Current index register, stepped on each release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (advance) begin
            idx <= idx_nxt;
        end
    end

    assign cur_base = RING_BASE + (32'(idx) << 3);
    assign nxt_base = RING_BASE + (32'(idx_nxt) << 3);

endmodule

// File: rtl/rxc_err_track.sv
// Error tracker: gathers the per-frame error indications that are
// reported at release time. PHY errors and the FCS/dribble state of the
// last byte live for the whole frame; bus parity is gathered per
// descriptor. Assumes 'take' marks a byte accepted into a buffer.
module rxc_err_track (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic desc_done,
    input  logic active,
    input  logic take,
    input  logic take_last,
    input  logic phy_err,
    input  logic fcs_err,
    input  logic dribble,
    input  logic bus_perr,
    output logic phy_seen,
    output logic bpe_seen,
    output logic fcs_q,
    output logic drib_q
);

    // Frame-scoped flags: cleared at frame start, captured on accepted bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phy_seen <= 1'b0;
            fcs_q    <= 1'b0;
            drib_q   <= 1'b0;
        end else if (frame_start) begin
            phy_seen <= 1'b0;
            fcs_q    <= 1'b0;
            drib_q   <= 1'b0;
        end else if (take) begin
            if (phy_err) begin
                phy_seen <= 1'b1;
            end
            if (take_last) begin
                fcs_q  <= fcs_err;
                drib_q <= dribble;
            end
        end
    end

    // Descriptor-scoped bus parity flag: cleared on each release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bpe_seen <= 1'b0;
        end else if (frame_start || desc_done) begin
            bpe_seen <= 1'b0;
        end else if (active && bus_perr) begin
            bpe_seen <= 1'b1;
        end
    end

endmodule

// File: rtl/rxc_status_build.sv
// Status builder: forms the flag byte written back on release. Framing
// and CRC are qualified by end of packet without overflow; the summary
// bit ORs every error source. Purely combinational.
module rxc_status_build
    import rxc_pkg::*;
(
    input  logic       end_seen,
    input  logic       first_buf,
    input  logic       oflo,
    input  logic       buff,
    input  logic       fcs,
    input  logic       drib,
    input  logic       phy_seen,
    input  logic       bpe_seen,
    input  logic       lookahead,
    input  logic       host_stp,
    output rxc_flags_t flags
);

    logic late_ok;

    // Apply the validity rules and combine the summary error.
    always_comb begin
        late_ok    = end_seen && !oflo;
        flags.own  = 1'b0;
        flags.fram = late_ok && fcs && drib;
        flags.crc  = late_ok && (fcs || phy_seen);
        flags.oflo = oflo;
        flags.buff = buff;
        flags.enp  = late_ok;
        flags.stp  = lookahead ? host_stp : first_buf;
        flags.err  = flags.fram || flags.oflo || flags.crc || flags.buff || bpe_seen;
    end

endmodule

// File: rtl/rx_desc_chain.sv
// Receive descriptor chaining engine (top). Waits for a frame, polls the
// current descriptor until owned, fetches its buffer address, stores the
// frame byte by byte, reads ahead to chain into further buffers, and
// releases each descriptor with one status write. Assumes the memory
// port completes each request with a one-cycle mem_ack and that the
// host never changes a descriptor while the engine owns it.
module rx_desc_chain
    import rxc_pkg::*;
#(
    parameter int          RING_LEN  = 4,
    parameter int          BUF_BYTES = 8,
    parameter logic [31:0] RING_BASE = 32'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lookahead_en,
    input  logic        bus_perr,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [7:0]  in_data,
    input  logic        in_last,
    input  logic        in_fcs_err,
    input  logic        in_dribble,
    input  logic        in_phy_err,
    input  logic        in_overflow,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [3:0]  mem_wstrb,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ack
);

    localparam int OFF_W = $clog2(BUF_BYTES + 1);
    localparam logic [OFF_W-1:0] OFF_FULL = OFF_W'(BUF_BYTES);

    rxc_state_t   state;
    rxc_wb_kind_t wb_kind;
    logic [STAT_KEEP_W-1:0] stat_keep;
    logic                   stat_stp;
    logic [STAT_KEEP_W-1:0] peek_keep;
    logic                   peek_stp;
    logic [31:0]  buf_addr;
    logic [OFF_W-1:0] offset;
    logic [7:0]   byte_q;
    logic         last_q;
    logic         first_q;
    logic         end_q;
    logic         oflo_q;
    logic         buff_q;
    logic [31:0]  cur_base;
    logic [31:0]  nxt_base;
    logic [31:0]  byte_addr;
    logic         buf_full;
    logic         take;
    logic         frame_start;
    logic         desc_done;
    logic         phy_seen;
    logic         bpe_seen;
    logic         fcs_q;
    logic         drib_q;
    rxc_flags_t   flags;

    assign buf_full    = (offset == OFF_FULL);
    assign in_ready    = ((state == ST_DATA) && !buf_full && !in_overflow) || (state == ST_DRAIN);
    assign take        = (state == ST_DATA) && in_valid && !buf_full && !in_overflow;
    assign frame_start = (state == ST_IDLE) && in_valid;
    assign desc_done   = (state == ST_WB) && mem_ack;
    assign byte_addr   = buf_addr + 32'(offset);

    rxc_ring_ptr #(
        .RING_LEN (RING_LEN),
        .RING_BASE(RING_BASE)
    ) u_ring_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (desc_done),
        .cur_base(cur_base),
        .nxt_base(nxt_base)
    );

    rxc_err_track u_err_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .desc_done  (desc_done),
        .active     (state != ST_IDLE),
        .take       (take),
        .take_last  (in_last),
        .phy_err    (in_phy_err),
        .fcs_err    (in_fcs_err),
        .dribble    (in_dribble),
        .bus_perr   (bus_perr),
        .phy_seen   (phy_seen),
        .bpe_seen   (bpe_seen),
        .fcs_q      (fcs_q),
        .drib_q     (drib_q)
    );

    rxc_status_build u_status_build (
        .end_seen (end_q),
        .first_buf(first_q),
        .oflo     (oflo_q),
        .buff     (buff_q),
        .fcs      (fcs_q),
        .drib     (drib_q),
        .phy_seen (phy_seen),
        .bpe_seen (bpe_seen),
        .lookahead(lookahead_en),
        .host_stp (stat_stp),
        .flags    (flags)
    );

    // Memory port: the state alone selects the request and its payload.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wstrb = '0;
        mem_wdata = '0;
        case (state)
            ST_RD_STAT: begin
                mem_req  = 1'b1;
                mem_addr = cur_base + 32'd4;
            end
            ST_RD_ADDR: begin
                mem_req  = 1'b1;
                mem_addr = cur_base;
            end
            ST_WR_BYTE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = byte_addr;
                mem_wstrb = 4'b0001 << byte_addr[1:0];
                mem_wdata = {4{byte_q}};
            end
            ST_PEEK: begin
                mem_req  = 1'b1;
                mem_addr = nxt_base + 32'd4;
            end
            ST_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_base + 32'd4;
                mem_wstrb = 4'hF;
                mem_wdata = {flags, stat_keep};
            end
            default: ;
        endcase
    end

    // Control sequencer: ownership polling, filling, chaining and release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            wb_kind   <= WB_END;
            stat_keep <= '0;
            stat_stp  <= 1'b0;
            peek_keep <= '0;
            peek_stp  <= 1'b0;
            buf_addr  <= '0;
            offset    <= '0;
            byte_q    <= '0;
            last_q    <= 1'b0;
            first_q   <= 1'b0;
            end_q     <= 1'b0;
            oflo_q    <= 1'b0;
            buff_q    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (in_valid) begin
                        state   <= ST_RD_STAT;
                        first_q <= 1'b1;
                        end_q   <= 1'b0;
                        oflo_q  <= 1'b0;
                        buff_q  <= 1'b0;
                    end
                end
                ST_RD_STAT: begin
                    if (mem_ack && mem_rdata[OWN_BIT]) begin
                        stat_keep <= mem_rdata[STAT_KEEP_W-1:0];
                        stat_stp  <= mem_rdata[STP_BIT];
                        state     <= ST_RD_ADDR;
                    end
                end
                ST_RD_ADDR: begin
                    if (mem_ack) begin
                        buf_addr <= mem_rdata;
                        offset   <= '0;
                        state    <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (in_valid) begin
                        if (buf_full) begin
                            state <= ST_PEEK;
                        end else if (in_overflow) begin
                            oflo_q  <= 1'b1;
                            wb_kind <= WB_ABORT;
                            state   <= ST_WB;
                        end else begin
                            byte_q <= in_data;
                            last_q <= in_last;
                            state  <= ST_WR_BYTE;
                        end
                    end
                end
                ST_WR_BYTE: begin
                    if (mem_ack) begin
                        offset <= offset + OFF_W'(1);
                        if (last_q) begin
                            end_q   <= 1'b1;
                            wb_kind <= WB_END;
                            state   <= ST_WB;
                        end else begin
                            state <= ST_DATA;
                        end
                    end
                end
                ST_PEEK: begin
                    if (in_valid && in_overflow) begin
                        oflo_q <= 1'b1;
                    end
                    if (mem_ack) begin
                        state <= ST_WB;
                        if (!mem_rdata[OWN_BIT]) begin
                            buff_q  <= 1'b1;
                            wb_kind <= WB_ABORT;
                        end else if (oflo_q || (in_valid && in_overflow)) begin
                            wb_kind <= WB_ABORT;
                        end else begin
                            peek_keep <= mem_rdata[STAT_KEEP_W-1:0];
                            peek_stp  <= mem_rdata[STP_BIT];
                            wb_kind   <= WB_CHAIN;
                        end
                    end
                end
                ST_WB: begin
                    if (mem_ack) begin
                        case (wb_kind)
                            WB_END:   state <= ST_IDLE;
                            WB_CHAIN: begin
                                stat_keep <= peek_keep;
                                stat_stp  <= peek_stp;
                                first_q   <= 1'b0;
                                state     <= ST_RD_ADDR;
                            end
                            default:  state <= ST_DRAIN;
                        endcase
                    end
                end
                ST_DRAIN: begin
                    if (in_valid && in_last) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rxc_chk.sv
// Protocol checker for rx_desc_chain, attached with bind below. Observes
// only the port-level memory and stream traffic.
module rxc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_ready,
    input logic       mem_req,
    input logic       mem_we,
    input logic [31:0] mem_addr,
    input logic [3:0] mem_wstrb,
    input logic [7:0] wflags,
    input logic       mem_ack
);

    logic wb_wr;
    logic byte_wr;

    assign wb_wr   = mem_req && mem_we && (mem_wstrb == 4'hF);
    assign byte_wr = mem_req && mem_we && (mem_wstrb != 4'hF);

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R3
    byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_wr |-> ($countones(mem_wstrb) == 1));

    // R1
    ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !mem_req);

    // R5
    own_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_wr |-> !wflags[7]);

    // R7
    err_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_wr && (|wflags[5:2]) |-> wflags[6]);

    // R8
    fram_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_wr && wflags[5] |-> wflags[0] && wflags[3] && !wflags[4]);

    // R9
    crc_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_wr && wflags[3] |-> wflags[0] && !wflags[4]);

    // R10
    buff_no_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_wr && wflags[2] |-> !wflags[0]);

endmodule

bind rx_desc_chain rxc_chk u_rxc_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wstrb(mem_wstrb),
    .wflags   (mem_wdata[31:24]),
    .mem_ack  (mem_ack)
);

// File: tb/rx_desc_chain_bench.sv
// Bench for rx_desc_chain: 4-entry ring at address 0, 8-byte buffers at
// 64 + 16*i, a one-cycle-ack memory model, and expected descriptor and
// buffer contents computed from the requirements.
module rx_desc_chain_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lookahead_en = 1'b0;
    logic        bus_perr = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        in_fcs_err = 1'b0;
    logic        in_dribble = 1'b0;
    logic        in_phy_err = 1'b0;
    logic        in_overflow = 1'b0;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [3:0]  mem_wstrb;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    logic [31:0] mem [0:63];
    logic        hw_en = 1'b0;
    logic [5:0]  hw_addr = '0;
    logic [31:0] hw_data = '0;

    int n_tests = 0;
    int n_fail = 0;
    int pos = 0;

    always #2 clk = ~clk;

    rx_desc_chain #(.RING_LEN(4), .BUF_BYTES(8), .RING_BASE(32'h0)) u_rx_desc_chain (
        .clk(clk), .rst_n(rst_n), .lookahead_en(lookahead_en), .bus_perr(bus_perr),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .in_fcs_err(in_fcs_err), .in_dribble(in_dribble), .in_phy_err(in_phy_err),
        .in_overflow(in_overflow), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wstrb(mem_wstrb), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    // Memory model: one-cycle acknowledge, plus bench-side host writes.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                if (mem_we) begin
                    for (int l = 0; l < 4; l++) begin
                        if (mem_wstrb[l]) mem[mem_addr[7:2]][8*l +: 8] <= mem_wdata[8*l +: 8];
                    end
                end else begin
                    mem_rdata <= mem[mem_addr[7:2]];
                end
            end
        end
        if (hw_en) mem[hw_addr] <= hw_data;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] dbyte(input int seed, input int j);
        return 8'((seed * 7 + j) & 255);
    endfunction

    function automatic logic [31:0] init_word(input int i, input bit own, input bit stp);
        return {own, 5'b0, stp, 1'b0, 24'(32'hA50 + i)};
    endfunction

    function automatic logic [7:0] rd_byte(input int a);
        return mem[a >> 2][8 * (a & 3) +: 8];
    endfunction

    function automatic logic [7:0] fl(input bit err, input bit fram, input bit oflo,
                                      input bit crc, input bit buff, input bit stp, input bit enp);
        return {1'b0, err, fram, oflo, crc, buff, stp, enp};
    endfunction

    task automatic host_wr(input int a, input logic [31:0] d);
        @(negedge clk);
        hw_en = 1'b1;
        hw_addr = 6'(a);
        hw_data = d;
        @(negedge clk);
        hw_en = 1'b0;
    endtask

    task automatic ring_init(input logic [3:0] own_mask, input logic [3:0] stp_mask);
        for (int i = 0; i < 4; i++) begin
            host_wr(2 * i, 32'(64 + 16 * i));
            host_wr(2 * i + 1, init_word(i, own_mask[i], stp_mask[i]));
        end
        for (int w = 16; w < 32; w++) host_wr(w, 32'h0);
    endtask

    task automatic send_frame(input int len, input bit fcs, input bit drib, input bit phy,
                              input int ovf_at, input int bpe_at, input int seed);
        for (int j = 0; j < len; j++) begin
            @(negedge clk);
            in_valid    = 1'b1;
            in_data     = dbyte(seed, j);
            in_last     = (j == len - 1);
            in_fcs_err  = fcs && (j == len - 1);
            in_dribble  = drib && (j == len - 1);
            in_phy_err  = phy && (j == 0);
            in_overflow = (j == ovf_at);
            bus_perr    = (j == bpe_at);
            #1;
            while (!in_ready) begin
                @(negedge clk);
                #1;
            end
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; in_fcs_err = 1'b0; in_dribble = 1'b0;
        in_phy_err = 1'b0; in_overflow = 1'b0; bus_perr = 1'b0;
        repeat (12) @(posedge clk);
        @(negedge clk);
    endtask

    // Checks a frame completed without chaining faults, starting at p.
    task automatic verify_good(input int p, input int len, input bit fcs, input bit drib,
                               input bit phy, input bit bpe, input int seed,
                               input bit la, input logic [3:0] stp_mask);
        int nbuf = (len + 7) / 8;
        for (int k = 0; k < nbuf; k++) begin
            int  i = (p + k) % 4;
            bit  last = (k == nbuf - 1);
            bit  fr = last && fcs && drib;
            bit  cr = last && (fcs || phy);
            bit  st = la ? stp_mask[i] : (k == 0);
            int  cnt = (len - 8 * k < 8) ? len - 8 * k : 8;
            chk($sformatf("R4 R5 R6 R7 R8 R9 R13 desc %0d len %0d", i, len), mem[2 * i + 1],
                {fl(fr || cr || (bpe && k == 0), fr, 1'b0, cr, 1'b0, st, last), 24'(32'hA50 + i)});
            for (int b = 0; b < cnt; b++) begin
                chk($sformatf("R3 desc %0d byte %0d", i, b), 32'(rd_byte(64 + 16 * i + b)),
                    32'(dbyte(seed, 8 * k + b)));
            end
        end
        if (nbuf < 4) begin
            int j = (p + nbuf) % 4;
            chk($sformatf("R5 untouched desc %0d", j), mem[2 * j + 1], init_word(j, 1'b1, stp_mask[j]));
        end
    endtask

    initial begin
        for (int w = 0; w < 64; w++) mem[w] = 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 in_ready after reset", 32'(in_ready), 32'h0);
        chk("R1 mem_req after reset", 32'(mem_req), 32'h0);
        rst_n = 1'b1;

        // Length sweep: fits, exact fits, chains and ring wraps.
        for (int len = 1; len <= 20; len++) begin
            ring_init(4'hF, 4'h0);
            send_frame(len, 1'b0, 1'b0, 1'b0, -1, -1, len);
            verify_good(pos, len, 1'b0, 1'b0, 1'b0, 1'b0, len, 1'b0, 4'h0);
            pos = (pos + (len + 7) / 8) % 4;
        end

        // All FCS / dribble / PHY combinations on a two-buffer frame.
        for (int c = 0; c < 8; c++) begin
            ring_init(4'hF, 4'h0);
            send_frame(13, c[0], c[1], c[2], -1, -1, 30 + c);
            verify_good(pos, 13, c[0], c[1], c[2], 1'b0, 30 + c, 1'b0, 4'h0);
            pos = (pos + 2) % 4;
        end

        // R7: bus parity alone sets only the summary bit.
        ring_init(4'hF, 4'h0);
        send_frame(5, 1'b0, 1'b0, 1'b0, -1, 0, 40);
        verify_good(pos, 5, 1'b0, 1'b0, 1'b0, 1'b1, 40, 1'b0, 4'h0);
        pos = (pos + 1) % 4;

        // R10: next descriptor not owned while chaining.
        ring_init(4'hF & ~(4'b1 << ((pos + 1) % 4)), 4'h0);
        send_frame(13, 1'b1, 1'b0, 1'b0, -1, -1, 50);
        chk("R10 buffer error flags", mem[2 * pos + 1], {fl(1, 0, 0, 0, 1, 1, 0), 24'(32'hA50 + pos)});
        for (int b = 0; b < 8; b++)
            chk("R10 R3 bytes before error", 32'(rd_byte(64 + 16 * pos + b)), 32'(dbyte(50, b)));
        pos = (pos + 1) % 4;
        chk("R10 unowned desc unmodified", mem[2 * pos + 1], init_word(pos, 1'b0, 1'b0));

        // R2: next frame waits on the unowned descriptor until the host hands it over.
        fork
            send_frame(3, 1'b0, 1'b0, 1'b0, -1, -1, 51);
            begin
                repeat (30) @(posedge clk);
                chk("R2 status while unowned", mem[2 * pos + 1], init_word(pos, 1'b0, 1'b0));
                chk("R2 no data while unowned", mem[16 + 4 * pos], 32'h0);
                host_wr(2 * pos + 1, init_word(pos, 1'b1, 1'b0));
            end
        join
        verify_good(pos, 3, 1'b0, 1'b0, 1'b0, 1'b0, 51, 1'b0, 4'h0);
        pos = (pos + 1) % 4;

        // R11: overflow in mid-buffer, with an FCS error that must not show.
        ring_init(4'hF, 4'h0);
        send_frame(13, 1'b1, 1'b1, 1'b0, 3, -1, 60);
        chk("R11 overflow flags", mem[2 * pos + 1], {fl(1, 0, 1, 0, 0, 1, 0), 24'(32'hA50 + pos)});
        for (int b = 0; b < 3; b++)
            chk("R11 bytes before overflow", 32'(rd_byte(64 + 16 * pos + b)), 32'(dbyte(60, b)));
        chk("R11 overflowed byte discarded", 32'(rd_byte(64 + 16 * pos + 3)), 32'h0);
        chk("R11 next desc untouched", mem[2 * ((pos + 1) % 4) + 1], init_word((pos + 1) % 4, 1'b1, 1'b0));
        pos = (pos + 1) % 4;

        // R11: overflow at the buffer boundary, next descriptor owned.
        ring_init(4'hF, 4'h0);
        send_frame(13, 1'b0, 1'b0, 1'b0, 8, -1, 61);
        chk("R11 boundary overflow flags", mem[2 * pos + 1], {fl(1, 0, 1, 0, 0, 1, 0), 24'(32'hA50 + pos)});
        chk("R11 boundary next untouched", mem[2 * ((pos + 1) % 4) + 1], init_word((pos + 1) % 4, 1'b1, 1'b0));
        chk("R11 boundary next buffer empty", mem[16 + 4 * ((pos + 1) % 4)], 32'h0);
        pos = (pos + 1) % 4;

        // R12: overflow together with an unowned next descriptor.
        ring_init(4'hF & ~(4'b1 << ((pos + 1) % 4)), 4'h0);
        send_frame(13, 1'b0, 1'b0, 1'b0, 8, -1, 62);
        chk("R12 buffer and overflow flags", mem[2 * pos + 1], {fl(1, 0, 1, 0, 1, 1, 0), 24'(32'hA50 + pos)});
        pos = (pos + 1) % 4;

        // R13: lookahead keeps the host start-of-packet bit on both buffers.
        lookahead_en = 1'b1;
        ring_init(4'hF, 4'b1 << ((pos + 1) % 4));
        send_frame(13, 1'b0, 1'b0, 1'b0, -1, -1, 70);
        verify_good(pos, 13, 1'b0, 1'b0, 1'b0, 1'b0, 70, 1'b1, 4'b1 << ((pos + 1) % 4));
        lookahead_en = 1'b0;

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule